// File: doc/BRIEF.md
# Wired-to-Message Interrupt Controller

This block collects a set of wired interrupt lines (64 by default) and turns every line that is active, unmasked and allowed to signal into an outbound interrupt message. A message carries an 8-bit vector and an 8-bit route byte, both programmed per line. The message leaves through a valid/ready handshake to a message transport outside the block.

Software programs the block through a small memory-mapped port. The port has 32-bit words with byte enables. Each line has one bit in each of several per-line banks: mask, message enable, trigger mode, polarity, a write-1-to-clear bank and two plain storage banks. Each line also has a route byte and a vector byte. Edge events are held in a latch until software clears them. A level line sends one message per assertion. When several lines are eligible, the lowest-numbered line goes first.

Top module: `irq_msg_bridge`

## Requirements
- R1: After reset every mask bit is 1. The message-enable, trigger, polarity and both storage banks are 0, every route byte is 0, the vector byte of line n equals n, and no message is offered. The word at 0x04 reads 0x003F0000, holding (lines - 1) in bits 23:16. The word at 0x00 reads 0.
- R2: Per-line bit banks sit at word pairs 0x20/0x24 (mask), 0x40/0x44 (message enable), 0x60/0x64 (trigger, 1 = edge), 0xC0/0xC4 and 0xE0/0xE4 (storage only) and 0x3E0/0x3E4 (polarity, 1 = low/falling). Line n is bit n%32 of word n/32. A write changes only the byte lanes whose `bus_be` bit is 1, and reads return the stored value one cycle after the request.
- R3: The route byte of line n is at byte address 0x100+n and the vector byte is at 0x200+n. Byte address A lies in word A with bits 1:0 cleared, in lane A[1:0], and a write changes only the enabled lanes.
- R4: A line whose mask bit is 1 or whose message-enable bit is 0 sends no message. A latched event is kept and is sent once the line is unblocked.
- R5: A line with trigger 0 is a level line, active high when polarity is 0 and active low when polarity is 1. It sends exactly one message per assertion, and it sends again after it deasserts and asserts again.
- R6: A line with trigger 1 latches a rising edge (polarity 0) or a falling edge (polarity 1). The latch survives the input returning to its idle level, and the line offers its message again after each acceptance for as long as the latch is set.
- R7: Writing 1 to a bit of the clear bank (0x80/0x84) clears that line's edge latch, or re-arms a level line so that it sends again while it is still active. Bits written 0 have no effect, and the clear bank reads 0.
- R8: When several lines are eligible, the lowest-numbered line is loaded first.
- R9: Once a message is offered, `msg_valid`, `msg_vector` and `msg_route` hold steady until `msg_ready` is seen high.
- R10: When a clear-bank write and a new edge on the same line fall in the same cycle, the new edge stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Wired interrupt lines, asynchronous |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address, word aligned |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_vector | output | 8 | Vector byte of the offered line |
| msg_route | output | 8 | Route byte of the offered line |

## Verification
The collision that matters is a clear-bank write for a line landing on the same clock edge as a fresh edge detection on that line. If the clear wins, the event is silently lost. The bench sets up the collision by raising a masked edge line and issuing the clear write so that it commits on the third edge after the input changes, which is when the synchronised edge is latched. It then unmasks the line and requires a message. A control run issues the same clear a few cycles later and requires silence. A second overlap, the acceptance of a level line's message in the same cycle as a clear write, is covered by a property on the latch and by the level re-arm sequence.

// File: rtl/irqmsg_pkg.sv
package irqmsg_pkg;

  // Region codes taken from address bits 9:5.
  localparam logic [4:0] RGN_ID    = 5'd0;
  localparam logic [4:0] RGN_MASK  = 5'd1;
  localparam logic [4:0] RGN_MSGEN = 5'd2;
  localparam logic [4:0] RGN_TRIG  = 5'd3;
  localparam logic [4:0] RGN_CLR   = 5'd4;
  localparam logic [4:0] RGN_AUX0  = 5'd6;
  localparam logic [4:0] RGN_AUX1  = 5'd7;
  localparam logic [4:0] RGN_POL   = 5'd31;

  // Byte-per-line regions taken from address bits 9:8.
  localparam logic [1:0] SEL_ROUTE = 2'b01;
  localparam logic [1:0] SEL_VEC   = 2'b10;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] merge_word(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    return (old_w & ~lane_mask(be)) | (new_w & lane_mask(be));
  endfunction

endpackage

// File: rtl/irqmsg_regs.sv
module irqmsg_regs
  import irqmsg_pkg::*;
#(
  parameter int N = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                we,
  input  logic [9:0]          addr,
  input  logic [3:0]          be,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [N-1:0]        mask_o,
  output logic [N-1:0]        msgen_o,
  output logic [N-1:0]        trig_o,
  output logic [N-1:0]        pol_o,
  output logic [N-1:0]        clr_o,
  output logic [N-1:0][7:0]   route_o,
  output logic [N-1:0][7:0]   vec_o
);
  localparam int NW = N / 32;

  logic [NW-1:0][31:0] mask_q, mask_d, en_q, en_d, trig_q, trig_d;
  logic [NW-1:0][31:0] pol_q, pol_d, aux0_q, aux0_d, aux1_q, aux1_d, clr_w;
  logic [N-1:0][7:0]   route_q, route_d, vec_q, vec_d;
  logic [31:0]         rdata_q, rdata_d;
  logic                wr, rd;
  logic [4:0]          region;
  logic [2:0]          widx;

  assign wr     = req & we;
  assign rd     = req & ~we;
  assign region = addr[9:5];
  assign widx   = addr[4:2];

  // Next-state for the stored registers and the clear pulse.
  always_comb begin
    mask_d  = mask_q;  en_d   = en_q;   trig_d = trig_q;
    pol_d   = pol_q;   aux0_d = aux0_q; aux1_d = aux1_q;
    route_d = route_q; vec_d  = vec_q;
    clr_w   = '0;
    for (int w = 0; w < NW; w++) begin
      if (wr && widx == 3'(w)) begin
        case (region)
          RGN_MASK:  mask_d[w] = merge_word(mask_q[w], wdata, be);
          RGN_MSGEN: en_d[w]   = merge_word(en_q[w],   wdata, be);
          RGN_TRIG:  trig_d[w] = merge_word(trig_q[w], wdata, be);
          RGN_POL:   pol_d[w]  = merge_word(pol_q[w],  wdata, be);
          RGN_AUX0:  aux0_d[w] = merge_word(aux0_q[w], wdata, be);
          RGN_AUX1:  aux1_d[w] = merge_word(aux1_q[w], wdata, be);
          RGN_CLR:   clr_w[w]  = wdata & lane_mask(be);
          default: ;
        endcase
      end
    end
    for (int l = 0; l < N; l++) begin
      if (wr && be[l % 4] && addr[7:2] == 6'(l / 4)) begin
        if (addr[9:8] == SEL_ROUTE) route_d[l] = wdata[8*(l%4) +: 8];
        if (addr[9:8] == SEL_VEC)   vec_d[l]   = wdata[8*(l%4) +: 8];
      end
    end
  end

  // Read multiplexer.
  always_comb begin
    rdata_d = '0;
    if (region == RGN_ID && widx == 3'd1) rdata_d = 32'(N - 1) << 16;
    for (int w = 0; w < NW; w++) begin
      if (widx == 3'(w)) begin
        case (region)
          RGN_MASK:  rdata_d = mask_q[w];
          RGN_MSGEN: rdata_d = en_q[w];
          RGN_TRIG:  rdata_d = trig_q[w];
          RGN_POL:   rdata_d = pol_q[w];
          RGN_AUX0:  rdata_d = aux0_q[w];
          RGN_AUX1:  rdata_d = aux1_q[w];
          default: ;
        endcase
      end
    end
    for (int l = 0; l < N; l++) begin
      if (addr[7:2] == 6'(l / 4)) begin
        if (addr[9:8] == SEL_ROUTE) rdata_d[8*(l%4) +: 8] = route_q[l];
        if (addr[9:8] == SEL_VEC)   rdata_d[8*(l%4) +: 8] = vec_q[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      en_q    <= '0;
      trig_q  <= '0;
      pol_q   <= '0;
      aux0_q  <= '0;
      aux1_q  <= '0;
      route_q <= '0;
      for (int l = 0; l < N; l++) vec_q[l] <= 8'(l);
      rdata_q <= '0;
    end else begin
      if (wr) begin
        mask_q  <= mask_d;
        en_q    <= en_d;
        trig_q  <= trig_d;
        pol_q   <= pol_d;
        aux0_q  <= aux0_d;
        aux1_q  <= aux1_d;
        route_q <= route_d;
        vec_q   <= vec_d;
      end
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rdata   = rdata_q;
  assign mask_o  = mask_q;
  assign msgen_o = en_q;
  assign trig_o  = trig_q;
  assign pol_o   = pol_q;
  assign clr_o   = clr_w;
  assign route_o = route_q;
  assign vec_o   = vec_q;

endmodule

// File: rtl/irqmsg_detect.sv
module irqmsg_detect #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] sent_set,
  output logic [N-1:0] pending,
  output logic [N-1:0] edge_set,
  output logic [N-1:0] latch_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q, prev_q, lat_q, sent_q;
    logic act, lat_d, sent_d;

    always_comb begin
      act         = s2_q ^ pol[g];
      edge_set[g] = trig[g] & act & ~prev_q;
      // A new event outranks a clear that commits in the same cycle.
      lat_d       = edge_set[g] | (lat_q & ~clr[g]);
      sent_d      = ~trig[g] & act & ~clr[g] & (sent_q | sent_set[g]);
      pending[g]  = lat_q | (~trig[g] & act & ~sent_q);
      latch_o[g]  = lat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
        sent_q <= 1'b0;
      end else begin
        s1_q   <= irq_in[g];
        s2_q   <= s1_q;
        prev_q <= act;
        lat_q  <= lat_d;
        sent_q <= sent_d;
      end
    end
  end

endmodule

// File: rtl/irqmsg_arb.sv
module irqmsg_arb #(
  parameter int N  = 64,
  parameter int LW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       elig,
  input  logic [N-1:0][7:0]  route_in,
  input  logic [N-1:0][7:0]  vec_in,
  input  logic               ready,
  output logic               valid,
  output logic [7:0]         vector,
  output logic [7:0]         route,
  output logic [LW-1:0]      line_o,
  output logic [N-1:0]       sent_set,
  output logic               load,
  output logic [LW-1:0]      pick
);
  logic          valid_q, valid_d, found;
  logic [LW-1:0] line_q;
  logic [7:0]    vec_q, rt_q;
  logic [N-1:0]  held, cand;

  always_comb begin
    held = '0;
    if (valid_q) held[line_q] = 1'b1;
    cand  = elig & ~held;
    found = 1'b0;
    pick  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        pick  = LW'(i);
      end
    end
    load     = found & (~valid_q | ready);
    valid_d  = load | (valid_q & ~ready);
    sent_set = (valid_q & ready) ? held : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      vec_q   <= '0;
      rt_q    <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) begin
        line_q <= pick;
        vec_q  <= vec_in[pick];
        rt_q   <= route_in[pick];
      end
    end
  end

  assign valid  = valid_q;
  assign vector = vec_q;
  assign route  = rt_q;
  assign line_o = line_q;

endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [9:0]           bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [7:0]           msg_route
);
  localparam int LW = $clog2(NUM_LINES);

  logic                         rst_m_q, rst_s_q;
  logic [NUM_LINES-1:0]         mask_w, msgen_w, trig_w, pol_w, clr_w;
  logic [NUM_LINES-1:0]         pend_w, eset_w, lat_w, elig_w, sent_w;
  logic [NUM_LINES-1:0][7:0]    route_w, vec_w;
  logic                         load_w;
  logic [LW-1:0]                pick_w, line_w;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  irqmsg_regs #(.N(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_s_q), .req(bus_req), .we(bus_we), .addr(bus_addr),
    .be(bus_be), .wdata(bus_wdata), .rdata(bus_rdata), .mask_o(mask_w),
    .msgen_o(msgen_w), .trig_o(trig_w), .pol_o(pol_w), .clr_o(clr_w),
    .route_o(route_w), .vec_o(vec_w)
  );

  irqmsg_detect #(.N(NUM_LINES)) u_detect (
    .clk(clk), .rst_n(rst_s_q), .irq_in(irq_in), .trig(trig_w), .pol(pol_w),
    .clr(clr_w), .sent_set(sent_w), .pending(pend_w), .edge_set(eset_w),
    .latch_o(lat_w)
  );

  assign elig_w = ~mask_w & msgen_w & pend_w;

  irqmsg_arb #(.N(NUM_LINES), .LW(LW)) u_arb (
    .clk(clk), .rst_n(rst_s_q), .elig(elig_w), .route_in(route_w),
    .vec_in(vec_w), .ready(msg_ready), .valid(msg_valid), .vector(msg_vector),
    .route(msg_route), .line_o(line_w), .sent_set(sent_w), .load(load_w),
    .pick(pick_w)
  );

endmodule

// File: rtl/irqmsg_checker.sv
module irqmsg_checker #(
  parameter int N  = 64,
  parameter int LW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_s,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [7:0]    msg_vector,
  input logic [7:0]    msg_route,
  input logic          load_en,
  input logic [LW-1:0] load_idx,
  input logic [LW-1:0] line_q,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  msgen,
  input logic [N-1:0]  elig,
  input logic [N-1:0]  lat,
  input logic [N-1:0]  clr,
  input logic [N-1:0]  eset
);
  logic [N-1:0] below, held;
  assign below = (N'(1) << load_idx) - N'(1);
  assign held  = msg_valid ? (N'(1) << line_q) : '0;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_route));

  p_unblocked_r4: assert property (@(posedge clk) disable iff (!rst_s)
    load_en |-> !mask[load_idx] && msgen[load_idx]);

  p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_s)
    load_en |-> ((elig & ~held & below) == '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> ((lat & $past(clr & ~eset)) == '0));

  p_latch_keep_r6: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (($past(lat & ~clr) & ~lat) == '0));

  p_new_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (($past(eset) & ~lat) == '0));

endmodule

bind irq_msg_bridge irqmsg_checker #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst_s(rst_s_q), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_route(msg_route), .load_en(load_w),
  .load_idx(pick_w), .line_q(line_w), .mask(mask_w), .msgen(msgen_w),
  .elig(elig_w), .lat(lat_w), .clr(clr_w), .eset(eset_w)
);

// File: tb/tb_irq_msg_bridge.sv
module tb_irq_msg_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq;
  logic        bus_req, bus_we, msg_ready, msg_valid;
  logic [9:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  msg_vector, msg_route;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_msg_bridge dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_route(msg_route)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_be = b; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_be = 4'hf;
    @(negedge clk);
    bus_req = 0;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic recv(output bit got, output logic [7:0] v, output logic [7:0] r);
    got = 0; v = 0; r = 0;
    for (int i = 0; i < 24 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        got = 1; v = msg_vector; r = msg_route;
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
      end
    end
  endtask

  task automatic expect_msg(input logic [7:0] ev, input logic [7:0] er, input string tag);
    bit got; logic [7:0] v, r;
    recv(got, v, r);
    chk(got && v == ev && r == er, tag, {15'd0, got, v, r}, {16'd1, ev, er});
  endtask

  task automatic expect_none(input string tag);
    bit seen = 0;
    repeat (8) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    chk(!seen, tag, 32'(seen), 32'd0);
  endtask

  task automatic drain();
    bit got; logic [7:0] v, r;
    recv(got, v, r);
  endtask

  function automatic logic [31:0] bit_in(input int n, input int w, input bit val);
    return (n / 32 == w && val) ? (32'd1 << (n % 32)) : 32'd0;
  endfunction

  task automatic cfg(input int n, input bit edge_m, input bit pol);
    for (int w = 0; w < 2; w++) begin
      wr(10'h060 + 10'(4*w), 4'hf, bit_in(n, w, edge_m));
      wr(10'h3E0 + 10'(4*w), 4'hf, bit_in(n, w, pol));
    end
  endtask

  task automatic unmask_only(input int n);
    for (int w = 0; w < 2; w++) wr(10'h020 + 10'(4*w), 4'hf, ~bit_in(n, w, 1'b1));
  endtask

  task automatic mask_all();
    wr(10'h020, 4'hf, '1); wr(10'h024, 4'hf, '1);
  endtask

  task automatic clear_all();
    wr(10'h080, 4'hf, '1); wr(10'h084, 4'hf, '1);
  endtask

  task automatic clear_line(input int n);
    wr(10'h080 + 10'(4*(n/32)), 4'hf, 32'd1 << (n % 32));
  endtask

  task automatic set_byte(input logic [9:0] base, input int n, input logic [7:0] val);
    wr(base + 10'(n & ~3), 4'(1 << (n % 4)), 32'(val) << (8 * (n % 4)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; irq = '0; bus_req = 0; bus_we = 0; bus_addr = '0; bus_be = '0;
    bus_wdata = '0; msg_ready = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(msg_valid == 0, "R1 no message after reset", 32'(msg_valid), 0);
    rd_chk(10'h020, 32'hFFFF_FFFF, "R1 mask word0");
    rd_chk(10'h024, 32'hFFFF_FFFF, "R1 mask word1");
    rd_chk(10'h040, 32'h0, "R1 msgen word0");
    rd_chk(10'h064, 32'h0, "R1 trigger word1");
    rd_chk(10'h3E4, 32'h0, "R1 polarity word1");
    rd_chk(10'h0C0, 32'h0, "R1 storage word");
    rd_chk(10'h200, 32'h0302_0100, "R1 vectors 0..3");
    rd_chk(10'h23C, 32'h3F3E_3D3C, "R1 vectors 60..63");
    rd_chk(10'h13C, 32'h0, "R1 routes 60..63");
    rd_chk(10'h004, 32'h003F_0000, "R1 id upper word");
    rd_chk(10'h000, 32'h0, "R1 id lower word");

    // R2 bank layout and byte enables
    wr(10'h0C0, 4'b0101, 32'hAABB_CCDD);
    rd_chk(10'h0C0, 32'h00BB_00DD, "R2 storage byte enables");
    wr(10'h0E4, 4'hf, 32'h1234_5678);
    rd_chk(10'h0E4, 32'h1234_5678, "R2 storage bank 2");
    wr(10'h024, 4'b0010, 32'h0);
    rd_chk(10'h024, 32'hFFFF_00FF, "R2 mask lane write");
    mask_all();
    rd_chk(10'h080, 32'h0, "R7 clear bank reads zero");

    // R3 byte registers
    set_byte(10'h100, 17, 8'h5A);
    rd_chk(10'h110, 32'h0000_5A00, "R3 route byte lane");
    set_byte(10'h200, 62, 8'hC7);
    rd_chk(10'h23C, 32'h3FC7_3D3C, "R3 vector byte lane");
    set_byte(10'h200, 62, 8'd62);

    wr(10'h040, 4'hf, '1); wr(10'h044, 4'hf, '1);

    // R8 / R9 priority and hold, level high lines 5, 17, 40
    cfg(0, 1'b0, 1'b0);
    clear_all();
    wr(10'h020, 4'hf, ~((32'd1 << 5) | (32'd1 << 17)));
    wr(10'h024, 4'hf, ~(32'd1 << 8));
    @(negedge clk); irq[5] = 1; irq[17] = 1; irq[40] = 1;
    repeat (5) @(negedge clk);
    chk(msg_valid && msg_vector == 8'd5, "R8 lowest line first", {23'd0, msg_valid, msg_vector}, 32'h105);
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_vector == 8'd5 && msg_route == 8'd0, "R9 held while not ready",
        {15'd0, msg_valid, msg_vector, msg_route}, 32'h10500);
    expect_msg(8'd5, 8'h00, "R8 first 5");
    expect_msg(8'd17, 8'h5A, "R8 second 17");
    expect_msg(8'd40, 8'h00, "R8 third 40");
    expect_none("R5 one message per assertion");
    irq[5] = 0; irq[17] = 0; irq[40] = 0;
    mask_all();

    // R5 / R7 level low line 9
    cfg(9, 1'b0, 1'b1);
    irq[9] = 1;
    repeat (5) @(negedge clk);
    clear_all();
    unmask_only(9);
    expect_none("R5 level low idle");
    irq[9] = 0;
    expect_msg(8'd9, 8'd0, "R5 level low asserted");
    expect_none("R5 level low once");
    clear_line(9);
    expect_msg(8'd9, 8'd0, "R7 level re-arm by clear");
    irq[9] = 1;
    repeat (5) @(negedge clk);
    irq[9] = 0;
    expect_msg(8'd9, 8'd0, "R5 re-assertion sends again");
    irq[9] = 1;
    mask_all();

    // R6 falling edge line 50
    cfg(50, 1'b1, 1'b1);
    irq[50] = 1;
    repeat (5) @(negedge clk);
    clear_all();
    unmask_only(50);
    irq[50] = 0;
    expect_msg(8'd50, 8'd0, "R6 falling edge");
    irq[50] = 1;
    expect_msg(8'd50, 8'd0, "R6 latch persists");
    clear_line(50);
    drain();
    expect_none("R7 edge latch cleared");
    mask_all();
    irq[50] = 0;

    // R4 message enable off, then on
    cfg(20, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    clear_all();
    wr(10'h040, 4'hf, ~(32'd1 << 20));
    unmask_only(20);
    irq[20] = 1;
    expect_none("R4 message enable off");
    wr(10'h040, 4'hf, '1);
    expect_msg(8'd20, 8'd0, "R4 kept event sent when enabled");
    clear_line(20);
    drain();
    mask_all();
    irq[20] = 0;

    // R4 / R7 masked line keeps event; zero bits in clear ignored
    cfg(33, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    clear_all();
    irq[33] = 1;
    expect_none("R4 masked line silent");
    wr(10'h084, 4'hf, ~(32'd1 << 1));
    unmask_only(33);
    expect_msg(8'd33, 8'd0, "R7 zero clear bit keeps latch");
    clear_line(33);
    drain();
    expect_none("R7 clear stops resend");
    mask_all();
    irq[33] = 0;

    // R10 clear commits on the same edge as the new event
    cfg(3, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    clear_all();
    @(negedge clk) irq[3] = 1;
    @(posedge clk);
    @(posedge clk);
    wr(10'h080, 4'hf, 32'd1 << 3);
    unmask_only(3);
    expect_msg(8'd3, 8'd0, "R10 new edge beats clear");
    clear_line(3);
    drain();
    mask_all();
    irq[3] = 0;
    repeat (5) @(negedge clk);
    clear_all();
    irq[3] = 1;
    repeat (6) @(negedge clk);
    clear_line(3);
    unmask_only(3);
    expect_none("R7 later clear removes event");
    mask_all();
    irq[3] = 0;

    // Random lines, modes, vectors and routes (R5 / R6)
    for (int it = 0; it < 24; it++) begin
      int n = $urandom_range(63, 0);
      bit em = 1'($urandom_range(1, 0));
      bit pl = 1'($urandom_range(1, 0));
      logic [7:0] v = 8'($urandom);
      logic [7:0] r = 8'($urandom);
      cfg(n, em, pl);
      irq[n] = pl;
      set_byte(10'h200, n, v);
      set_byte(10'h100, n, r);
      repeat (5) @(negedge clk);
      clear_all();
      unmask_only(n);
      expect_none(em ? "R6 random idle" : "R5 random idle");
      irq[n] = ~pl;
      expect_msg(v, r, em ? "R6 random edge message" : "R5 random level message");
      if (em) begin
        expect_msg(v, r, "R6 random edge resend");
        clear_line(n);
        drain();
        expect_none("R7 random edge cleared");
      end else begin
        expect_none("R5 random level once");
        irq[n] = pl;
      end
      mask_all();
      irq[n] = 0;
      drain();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule